// File: doc/BRIEF.md
# Multi-mode quadrature and edge counter

This block turns two input signals, A and B, into a signed 32-bit event count. A 5-bit mode input picks how the pair is read: as an A-B quadrature encoder, as a level or edge counter on A, as an up/down counter where A counts up and B counts down, or as a clock/direction pair where A edges step the count and B sets the direction. Both inputs pass through an optional 3-of-3 glitch filter whose sample rate can be divided down, so slow, noisy encoder lines can be cleaned before decoding.

A 32-bit window length picks how the count is reported. A window of zero gives a running position total that changes whenever a step is decoded. A non-zero window gives the number of steps seen in each window of that many system clocks, which is a velocity reading. An event flag goes high whenever the result register is refreshed and stays high until the host acknowledges it. Dropping the enable input zeroes the count at any time. While it is low, the result register shows the step the decoder would apply in that clock (0, +1 or -1) and the flag stays low.

Top module: `edge_count_unit`

## Requirements
- R1: The count is 32 bits and wraps modulo 2^32; stepping down from zero gives 32'hFFFF_FFFF, then 32'hFFFF_FFFE, and so on.
- R2: Mode 5'b01011 decodes quadrature on every edge: the state sequence {A,B} = 00, 10, 11, 01, 00 (A leads B) adds one per transition, and the reverse sequence subtracts one per transition.
- R3: In mode 5'b01011, a clock in which both A and B change leaves the count unchanged.
- R4: Mode 5'b01100 adds one for every clock in which A is high; mode 5'b01101 adds one for every rising edge of A.
- R5: Mode 5'b01110 adds one for every clock with A high and subtracts one for every clock with B high, so both high gives no change; mode 5'b01111 does the same with the rising edges of A and B.
- R6: Mode 5'b11111 adds one on each rising edge of A while B is low and subtracts one on each rising edge of A while B is high; B alone never changes the count.
- R7: While enable is low the count is cleared, the flag is low, and the result equals the current step in two's complement (0, 1 or 32'hFFFF_FFFF); counting restarts from zero when enable returns high.
- R8: With a window length of 0 the result shows the running total, and the flag is set on every clock in which the total changes.
- R9: With a window length X > 0 the result is refreshed once every X clocks with the count of steps taken in that window, the flag is set at each refresh, and the next window starts from zero.
- R10: Once set, the flag stays high until a clock with ack high clears it; a new refresh in the same clock as ack keeps it high.
- R11: A change of the mode input clears the count, the window timer, the flag and the result.
- R12: Filter select 3'b0xx passes the inputs straight through; 3'b1nn accepts a new input level only after three consecutive equal samples, taken every clock for nn=00, every 8 clocks for 01, every 64 for 10 and every 512 for 11.
- R13: Any mode code not listed above holds the result at 0 and the flag low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Counter run; low zeroes the count and shows the step value |
| in_a | input | 1 | Input A (count or clock line) |
| in_b | input | 1 | Input B (count-down or direction line) |
| mode | input | 5 | Counting mode select |
| filt_sel | input | 3 | Input filter enable and sample-rate select |
| win_len | input | 32 | Window length in clocks; 0 selects running total |
| ack | input | 1 | Clears the event flag |
| result | output | 32 | Result register: total, window count or step value |
| flag | output | 1 | Event flag, set on each result refresh |

## Verification
The assertions watch, on every cycle, that the flag is low and the result holds only 0, +1 or -1 while enable is low, that the flag is not lost without an acknowledge, that unsupported modes keep the result at zero, that the window timer stays inside the window, that illegal quadrature jumps and non-edge clock/direction cycles yield no step, and that the filter only moves to a level seen three samples in a row. The actual count values (the direction of each quadrature sequence, the up/down cancellation, wrap below zero, the per-window totals, zeroing through enable and glitch rejection at two sample rates) are only shown by the bench's directed scenarios, which compare the result register against counts worked out from the stimulus.

// File: rtl/ecu_pkg.sv
package ecu_pkg;

    typedef enum logic [4:0] {
        M_OFF    = 5'b00000,
        M_QUAD   = 5'b01011,
        M_AHI    = 5'b01100,
        M_ARISE  = 5'b01101,
        M_LVL    = 5'b01110,
        M_EDGE   = 5'b01111,
        M_CLKDIR = 5'b11111
    } count_mode_e;

    typedef logic signed [1:0] step_t;

    localparam step_t STEP_UP   = 2'sb01;
    localparam step_t STEP_DOWN = 2'sb11;
    localparam step_t STEP_NONE = 2'sb00;

    function automatic logic mode_supported(input logic [4:0] m);
        case (m)
            M_QUAD, M_AHI, M_ARISE, M_LVL, M_EDGE, M_CLKDIR: mode_supported = 1'b1;
            default:                                           mode_supported = 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/ecu_filter.sv
module ecu_filter #(
    parameter int TAPS       = 3,
    parameter int RATE_SHIFT = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] sel,
    input  logic       din,
    output logic       dout
);
    localparam int PRE_W = 3 * RATE_SHIFT;

    typedef struct packed {
        logic             raw;
        logic [TAPS-1:0]  hist;
        logic             out;
        logic [PRE_W-1:0] pre;
    } filt_st_t;

    filt_st_t st_q, st_d;
    logic             bypass;
    logic             tick;
    logic [PRE_W-1:0] mask;

    always_comb begin
        bypass = ~sel[2];
        mask   = PRE_W'((32'd1 << (RATE_SHIFT * int'(sel[1:0]))) - 32'd1);
        tick   = bypass || ((st_q.pre & mask) == '0);
        st_d       = st_q;
        st_d.raw   = din;
        st_d.pre   = st_q.pre + 1'b1;
        if (tick) begin
            st_d.hist = {st_q.hist[TAPS-2:0], st_q.raw};
        end
        if (bypass) begin
            st_d.out = st_q.raw;
        end else if (tick) begin
            if (&st_d.hist)       st_d.out = 1'b1;
            else if (~|st_d.hist) st_d.out = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dout = bypass ? st_q.raw : st_q.out;

    // R12
    filter_agree_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(bypass) && $changed(st_q.out)) |-> (st_q.hist == {TAPS{st_q.out}}));

endmodule

// File: rtl/ecu_step.sv
module ecu_step
    import ecu_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [4:0] mode,
    input  logic       a,
    input  logic       b,
    output step_t      step
);
    typedef struct packed {
        logic prev_a;
        logic prev_b;
    } step_st_t;

    step_st_t st_q, st_d;
    logic rise_a, rise_b;

    function automatic step_t updown(input logic inc, input logic dec);
        case ({inc, dec})
            2'b10:   updown = STEP_UP;
            2'b01:   updown = STEP_DOWN;
            default: updown = STEP_NONE;
        endcase
    endfunction

    always_comb begin
        st_d.prev_a = a;
        st_d.prev_b = b;
        rise_a = a & ~st_q.prev_a;
        rise_b = b & ~st_q.prev_b;
        step   = STEP_NONE;
        case (mode)
            M_QUAD: begin
                case ({st_q.prev_a, st_q.prev_b, a, b})
                    4'b0010, 4'b1011, 4'b1101, 4'b0100: step = STEP_UP;
                    4'b0001, 4'b0111, 4'b1110, 4'b1000: step = STEP_DOWN;
                    default:                            step = STEP_NONE;
                endcase
            end
            M_AHI:    step = updown(a, 1'b0);
            M_ARISE:  step = updown(rise_a, 1'b0);
            M_LVL:    step = updown(a, b);
            M_EDGE:   step = updown(rise_a, rise_b);
            M_CLKDIR: step = updown(rise_a & ~b, rise_a & b);
            default:  step = STEP_NONE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R3
    quad_jump_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == M_QUAD && a != st_q.prev_a && b != st_q.prev_b) |-> (step == STEP_NONE));

    // R6
    clkdir_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == M_CLKDIR && !(a && !st_q.prev_a)) |-> (step == STEP_NONE));

endmodule

// File: rtl/ecu_accum.sv
module ecu_accum
    import ecu_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [4:0]       mode,
    input  step_t            step,
    input  logic [CNT_W-1:0] win_len,
    input  logic             ack,
    output logic [CNT_W-1:0] result,
    output logic             flag
);
    typedef struct packed {
        logic [CNT_W-1:0] acc;
        logic [CNT_W-1:0] timer;
        logic [CNT_W-1:0] res;
        logic             flag;
        logic [4:0]       mode;
    } acc_st_t;

    acc_st_t st_q, st_d;
    logic [CNT_W-1:0] step_ext;
    logic [CNT_W-1:0] sum;
    logic             win_end;

    always_comb begin
        step_ext = {{(CNT_W-2){step[1]}}, step};
        sum      = st_q.acc + step_ext;
        win_end  = (st_q.timer >= win_len - 1'b1);
        st_d      = st_q;
        st_d.mode = mode;
        st_d.flag = st_q.flag & ~ack;
        if (!enable) begin
            st_d.acc   = '0;
            st_d.timer = '0;
            st_d.flag  = 1'b0;
            st_d.res   = step_ext;
        end else if (mode != st_q.mode || !mode_supported(mode)) begin
            st_d.acc   = '0;
            st_d.timer = '0;
            st_d.flag  = 1'b0;
            st_d.res   = '0;
        end else if (win_len == '0) begin
            st_d.acc   = sum;
            st_d.timer = '0;
            st_d.res   = sum;
            if (step != STEP_NONE) st_d.flag = 1'b1;
        end else if (win_end) begin
            st_d.acc   = '0;
            st_d.timer = '0;
            st_d.res   = sum;
            st_d.flag  = 1'b1;
        end else begin
            st_d.acc   = sum;
            st_d.timer = st_q.timer + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign result = st_q.res;
    assign flag   = st_q.flag;

    // R7
    zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !flag);

    // R7
    zero_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (result == '0 || result == CNT_W'(1) || result == '1));

    // R10
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !ack && enable && mode == st_q.mode) |=> flag);

    // R9
    win_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && win_len != '0 && $stable(win_len)) |-> (st_q.timer < win_len));

    // R13
    bad_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_supported(mode) |=> (result == '0 && !flag));

endmodule

// File: rtl/edge_count_unit.sv
module edge_count_unit
    import ecu_pkg::*;
#(
    parameter int CNT_W      = 32,
    parameter int TAPS       = 3,
    parameter int RATE_SHIFT = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             in_a,
    input  logic             in_b,
    input  logic [4:0]       mode,
    input  logic [2:0]       filt_sel,
    input  logic [CNT_W-1:0] win_len,
    input  logic             ack,
    output logic [CNT_W-1:0] result,
    output logic             flag
);
    localparam int N_IN = 2;

    logic [N_IN-1:0] raw_in;
    logic [N_IN-1:0] clean_in;
    step_t           step;

    assign raw_in = {in_b, in_a};

    for (genvar gi = 0; gi < N_IN; gi++) begin : g_filt
        ecu_filter #(
            .TAPS       (TAPS),
            .RATE_SHIFT (RATE_SHIFT)
        ) filt_i (
            .clk   (clk),
            .rst_n (rst_n),
            .sel   (filt_sel),
            .din   (raw_in[gi]),
            .dout  (clean_in[gi])
        );
    end

    ecu_step step_i (
        .clk   (clk),
        .rst_n (rst_n),
        .mode  (mode),
        .a     (clean_in[0]),
        .b     (clean_in[1]),
        .step  (step)
    );

    ecu_accum #(
        .CNT_W (CNT_W)
    ) accum_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .enable  (enable),
        .mode    (mode),
        .step    (step),
        .win_len (win_len),
        .ack     (ack),
        .result  (result),
        .flag    (flag)
    );

endmodule

// File: tb/edge_count_unit_tb_top.sv
module edge_count_unit_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic        in_a = 1'b0;
    logic        in_b = 1'b0;
    logic [4:0]  mode = 5'b00000;
    logic [2:0]  filt_sel = 3'b000;
    logic [31:0] win_len = 32'd0;
    logic        ack = 1'b0;
    logic [31:0] result;
    logic        flag;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    edge_count_unit dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (enable),
        .in_a     (in_a),
        .in_b     (in_b),
        .mode     (mode),
        .filt_sel (filt_sel),
        .win_len  (win_len),
        .ack      (ack),
        .result   (result),
        .flag     (flag)
    );

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic set_mode(input logic [4:0] m);
        mode = m;
        cyc(3);
    endtask

    task automatic pulse_a(input int hi, input int lo);
        in_a = 1'b1; cyc(hi);
        in_a = 1'b0; cyc(lo);
    endtask

    task automatic do_ack();
        ack = 1'b1; cyc(1);
        ack = 1'b0;
    endtask

    task automatic t_reset();
        check("R13 reset result", result, 32'd0);
        check("R13 reset flag", {31'd0, flag}, 32'd0);
    endtask

    task automatic t_level_count();
        enable = 1'b1;
        set_mode(5'b01100);
        in_a = 1'b1; cyc(7);
        in_a = 1'b0; cyc(3);
        check("R4 A-high count", result, 32'd7);
        check("R8 flag after change", {31'd0, flag}, 32'd1);
        cyc(4);
        check("R10 flag held", {31'd0, flag}, 32'd1);
        do_ack();
        check("R10 flag cleared", {31'd0, flag}, 32'd0);
    endtask

    task automatic t_rise_count();
        set_mode(5'b01101);
        check("R11 cleared on mode change", result, 32'd0);
        pulse_a(2, 2); pulse_a(2, 2); pulse_a(2, 3);
        check("R4 A-rise count", result, 32'd3);
    endtask

    task automatic t_updown_level();
        set_mode(5'b01110);
        in_a = 1'b1; in_b = 1'b1; cyc(5);
        in_a = 1'b0; in_b = 1'b0; cyc(3);
        check("R5 both high cancel", result, 32'd0);
        in_b = 1'b1; cyc(4);
        in_b = 1'b0; cyc(3);
        check("R1 wrap below zero", result, 32'hFFFF_FFFC);
        in_a = 1'b1; cyc(6);
        in_a = 1'b0; cyc(3);
        check("R5 level up/down", result, 32'd2);
    endtask

    task automatic t_updown_edge();
        set_mode(5'b01111);
        in_a = 1'b1; in_b = 1'b1; cyc(3);
        in_a = 1'b0; in_b = 1'b0; cyc(3);
        check("R5 simultaneous edges cancel", result, 32'd0);
        pulse_a(3, 2); pulse_a(3, 2);
        in_b = 1'b1; cyc(3);
        in_b = 1'b0; cyc(3);
        check("R5 edge up/down", result, 32'd1);
    endtask

    task automatic t_quad();
        set_mode(5'b01011);
        in_a = 1'b1; cyc(2);
        in_b = 1'b1; cyc(2);
        in_a = 1'b0; cyc(2);
        in_b = 1'b0; cyc(3);
        check("R2 forward sequence", result, 32'd4);
        in_b = 1'b1; cyc(2);
        in_a = 1'b1; cyc(2);
        in_b = 1'b0; cyc(2);
        in_a = 1'b0; cyc(3);
        check("R2 reverse sequence", result, 32'd0);
        in_a = 1'b1; in_b = 1'b1; cyc(3);
        in_a = 1'b0; in_b = 1'b0; cyc(3);
        check("R3 illegal jumps", result, 32'd0);
    endtask

    task automatic t_clkdir();
        set_mode(5'b11111);
        in_b = 1'b0; cyc(2);
        pulse_a(2, 2); pulse_a(2, 2); pulse_a(2, 3);
        check("R6 count up", result, 32'd3);
        in_b = 1'b1; cyc(2);
        for (int i = 0; i < 5; i++) pulse_a(1, 3);
        in_b = 1'b0; cyc(3);
        check("R6 count down", result, 32'hFFFF_FFFE);
    endtask

    task automatic t_enable_zero();
        set_mode(5'b01110);
        in_a = 1'b1; cyc(3);
        in_a = 1'b0; cyc(3);
        check("R7 pre-zero count", result, 32'd3);
        enable = 1'b0; in_b = 1'b1; cyc(3);
        check("R7 step -1 shown", result, 32'hFFFF_FFFF);
        check("R7 flag low", {31'd0, flag}, 32'd0);
        in_b = 1'b0; in_a = 1'b1; cyc(3);
        check("R7 step +1 shown", result, 32'd1);
        in_a = 1'b0; cyc(3);
        check("R7 step 0 shown", result, 32'd0);
        enable = 1'b1; cyc(2);
        in_a = 1'b1; cyc(2);
        in_a = 1'b0; cyc(3);
        check("R7 restart from zero", result, 32'd2);
        do_ack();
    endtask

    task automatic wait_flag(input string tag);
        int n = 0;
        while (!flag && n < 200) begin
            cyc(1); n++;
        end
        check(tag, {31'd0, flag}, 32'd1);
    endtask

    task automatic t_periodic();
        win_len = 32'd10;
        in_a = 1'b1; in_b = 1'b0;
        set_mode(5'b01100);
        wait_flag("R9 first window flag");
        check("R9 first window count", result, 32'd10);
        do_ack();
        wait_flag("R9 second window flag");
        check("R9 second window count", result, 32'd10);
        in_a = 1'b0;
        do_ack();
        wait_flag("R9 idle window flag");
        do_ack();
        wait_flag("R9 idle window flag 2");
        check("R9 idle window count", result, 32'd0);
        do_ack();
        win_len = 32'd0;
    endtask

    task automatic t_filter();
        set_mode(5'b01101);
        filt_sel = 3'b100; cyc(4);
        pulse_a(2, 6);
        check("R12 glitch rejected", result, 32'd0);
        pulse_a(6, 8);
        check("R12 steady level passed", result, 32'd1);
        filt_sel = 3'b101; cyc(40);
        pulse_a(10, 40);
        check("R12 slow rate rejects short pulse", result, 32'd1);
        pulse_a(40, 40);
        check("R12 slow rate passes long pulse", result, 32'd2);
        filt_sel = 3'b000; cyc(3);
        pulse_a(1, 3);
        check("R12 bypass passes glitch", result, 32'd3);
    endtask

    task automatic t_bad_mode();
        set_mode(5'b10000);
        pulse_a(2, 2); pulse_a(2, 3);
        check("R13 unsupported result", result, 32'd0);
        check("R13 unsupported flag", {31'd0, flag}, 32'd0);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        cyc(3);
        rst_n = 1'b1;
        cyc(2);
        t_reset();
        t_level_count();
        t_rise_count();
        t_updown_level();
        t_updown_edge();
        t_quad();
        t_clkdir();
        t_enable_zero();
        t_periodic();
        t_filter();
        t_bad_mode();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule